// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block controls one bank of 32 general-purpose lines, grouped as four 8-bit ports (lines 0-7 are port 0, lines 8-15 port 1, and so on). Software reaches it through a simple 32-bit register port. Through that port it sets which lines drive their pads, writes the output values, chooses between normal use and a dedicated peripheral for each line, and sets up edge detection for each line.

Pad inputs pass through a two-flop synchronizer. A line raises a sticky status flag when its synchronized value changes in a direction that the line's 2-bit detection field selects. All status flags are ORed onto a single interrupt output. Software reads the status word and clears flags by writing ones.

The detection fields sit in two 32-bit configuration words with 16 bits per port. Within each word the two ports are swapped, so the lower-numbered port of a pair occupies the upper half-word.

Top module: `edge_gpio_bank`

## Requirements
- R1: After reset every register reads zero, `pinOe`, `pinAltSel` and `pinOut` are zero, and `irqOut` is low.
- R2: The word at offset 0x08 holds the direction, with bit value 1 meaning output and 0 meaning input. Bit i of it drives `pinOe[i]`. The word at offset 0x0C holds the output latch, which drives `pinOut`. Both take effect on the clock edge that accepts the write.
- R3: A read of 0x0C returns the latch bit for lines whose direction is output. For lines whose direction is input it returns the synchronized pad value, which follows a change on `pinIn` after two rising clock edges.
- R4: The word at offset 0x00 is the function select, with 1 handing the line to a dedicated peripheral and 0 meaning normal use. It reads back as written and drives `pinAltSel`.
- R5: Each line's 2-bit detection field encodes 0 = none, 1 = falling edge, 2 = rising edge and 3 = both edges. A qualifying change on `pinIn` sets the line's status flag on the third rising clock edge after the change.
- R6: For line L on port p = L/8 at pin n = L%8, the detection field starts at bit 2*(8*(p XOR 1)+n) of the 64-bit value {word 0x18, word 0x14}. Ports 0 and 1 therefore live in word 0x14 and ports 2 and 3 in word 0x18.
- R7: The status word at offset 0x10 holds one flag per line. Writing 1 to a bit clears that flag, and writing 0 leaves it as it was.
- R8: If a new edge and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R9: `irqOut` is high exactly when at least one status flag is set.
- R10: Accesses to any other address read zero and change nothing. This covers 0x04, 0x1C and any address whose two low bits are not zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, accepted on the rising clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| pinIn | input | 32 | Pad input values |
| pinOut | output | 32 | Output latch values |
| pinOe | output | 32 | Output enable per line |
| pinAltSel | output | 32 | Peripheral hand-over per line |
| irqOut | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: four 8-bit ports and a 5-bit address. With these values both configuration words are in use, and both swapped port pairs can be told apart. The tests pick lines on different ports with the same pin number, so that a field placed in the wrong half-word shows up as a flag on the wrong line. The tests also time one pad edge to land in the same cycle as a write-1 clear, and they check the two-edge input latency and the three-edge flag latency cycle by cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int OFF_FUNC  = 'h00;
  localparam int OFF_DIR   = 'h08;
  localparam int OFF_DATA  = 'h0C;
  localparam int OFF_STAT  = 'h10;
  localparam int OFF_CFGLO = 'h14;
  localparam int OFF_CFGHI = 'h18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_FUNC,
    SEL_DIR,
    SEL_DATA,
    SEL_STAT,
    SEL_CFGLO,
    SEL_CFGHI
  } regSel_e;

  typedef struct packed {
    logic    wrFunc;
    logic    wrDir;
    logic    wrData;
    logic    wrStat;
    logic    wrCfgLo;
    logic    wrCfgHi;
    regSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] syncOut,
  output logic [WIDTH-1:0] prevOut
);

  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta    <= '0;
      syncOut <= '0;
      prevOut <= '0;
    end else begin
      meta    <= pinIn;
      syncOut <= meta;
      prevOut <= syncOut;
    end
  end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output strobe_t           strb
);

  regSel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if (busAddr == ADDR_W'(OFF_FUNC))  sel = SEL_FUNC;
    if (busAddr == ADDR_W'(OFF_DIR))   sel = SEL_DIR;
    if (busAddr == ADDR_W'(OFF_DATA))  sel = SEL_DATA;
    if (busAddr == ADDR_W'(OFF_STAT))  sel = SEL_STAT;
    if (busAddr == ADDR_W'(OFF_CFGLO)) sel = SEL_CFGLO;
    if (busAddr == ADDR_W'(OFF_CFGHI)) sel = SEL_CFGHI;
  end

  always_comb begin
    strb         = '0;
    strb.rdSel   = sel;
    strb.wrFunc  = busWrEn && (sel == SEL_FUNC);
    strb.wrDir   = busWrEn && (sel == SEL_DIR);
    strb.wrData  = busWrEn && (sel == SEL_DATA);
    strb.wrStat  = busWrEn && (sel == SEL_STAT);
    strb.wrCfgLo = busWrEn && (sel == SEL_CFGLO);
    strb.wrCfgHi = busWrEn && (sel == SEL_CFGHI);
  end

endmodule

// File: rtl/gpio_bank_dpath.sv
module gpio_bank_dpath
  import gpio_bank_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int NUM_PORTS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [PORT_W*NUM_PORTS-1:0] wrData,
  input  logic [PORT_W*NUM_PORTS-1:0] syncIn,
  input  logic [PORT_W*NUM_PORTS-1:0] prevIn,
  output logic [PORT_W*NUM_PORTS-1:0] rdData,
  output logic [PORT_W*NUM_PORTS-1:0] pinOut,
  output logic [PORT_W*NUM_PORTS-1:0] pinOe,
  output logic [PORT_W*NUM_PORTS-1:0] pinAltSel,
  output logic                   irqOut
);

  localparam int NUM_LINES = PORT_W * NUM_PORTS;
  localparam int CFG_W     = 2 * NUM_LINES;

  logic [NUM_LINES-1:0] funcSel, dirReg, outLatch, status, cfgLo, cfgHi;
  logic [NUM_LINES-1:0] edgeHit, clrMask, dataView;
  logic [CFG_W-1:0]     cfgAll;

  assign cfgAll = {cfgHi, cfgLo};

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int PORT = i / PORT_W;
    localparam int PIN  = i % PORT_W;
    localparam int POS  = 2 * (PORT_W * (PORT ^ 1) + PIN);
    logic [1:0] mode;
    assign mode = cfgAll[POS +: 2];
    assign edgeHit[i] = (mode[0] & prevIn[i] & ~syncIn[i]) |
                        (mode[1] & ~prevIn[i] & syncIn[i]);

    // R7: a write-1 clears a flag when no new edge arrives
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
      (strb.wrStat && wrData[i] && !edgeHit[i]) |=> !status[i]);
    // R7: a flag with no clear and no edge holds its value
    a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
      (status[i] && !(strb.wrStat && wrData[i])) |=> status[i]);
    // R8: a new edge always leaves the flag set, clear or not
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      edgeHit[i] |=> status[i]);
  end

  assign clrMask = strb.wrStat ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      funcSel  <= '0;
      dirReg   <= '0;
      outLatch <= '0;
      status   <= '0;
      cfgLo    <= '0;
      cfgHi    <= '0;
    end else begin
      if (strb.wrFunc)  funcSel  <= wrData;
      if (strb.wrDir)   dirReg   <= wrData;
      if (strb.wrData)  outLatch <= wrData;
      if (strb.wrCfgLo) cfgLo    <= wrData;
      if (strb.wrCfgHi) cfgHi    <= wrData;
      status <= (status & ~clrMask) | edgeHit;
    end
  end

  assign dataView = (outLatch & dirReg) | (syncIn & ~dirReg);

  always_comb begin
    case (strb.rdSel)
      SEL_FUNC:  rdData = funcSel;
      SEL_DIR:   rdData = dirReg;
      SEL_DATA:  rdData = dataView;
      SEL_STAT:  rdData = status;
      SEL_CFGLO: rdData = cfgLo;
      SEL_CFGHI: rdData = cfgHi;
      default:   rdData = '0;
    endcase
  end

  assign pinOut    = outLatch;
  assign pinOe     = dirReg;
  assign pinAltSel = funcSel;
  assign irqOut    = |status;

  // R2: a direction write shows up on the enables one edge later
  a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDir |=> (pinOe == $past(wrData)));
  // R9: the interrupt can only rise after some line saw an edge
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(|edgeHit));

endmodule

// File: rtl/edge_gpio_bank.sv
module edge_gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busWrEn,
  input  logic [PORT_W*NUM_PORTS-1:0] busWrData,
  output logic [PORT_W*NUM_PORTS-1:0] busRdData,
  input  logic [PORT_W*NUM_PORTS-1:0] pinIn,
  output logic [PORT_W*NUM_PORTS-1:0] pinOut,
  output logic [PORT_W*NUM_PORTS-1:0] pinOe,
  output logic [PORT_W*NUM_PORTS-1:0] pinAltSel,
  output logic                        irqOut
);

  localparam int NUM_LINES = PORT_W * NUM_PORTS;

  strobe_t              strb;
  logic [NUM_LINES-1:0] syncVal, prevVal;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strb    (strb)
  );

  gpio_bank_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .syncOut (syncVal),
    .prevOut (prevVal)
  );

  gpio_bank_dpath #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (busWrData),
    .syncIn    (syncVal),
    .prevIn    (prevVal),
    .rdData    (busRdData),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .pinAltSel (pinAltSel),
    .irqOut    (irqOut)
  );

endmodule

// File: tb/edge_gpio_bank_bench.sv
module edge_gpio_bank_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOe, pinAltSel;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_gpio_bank u_edge_gpio_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .pinAltSel(pinAltSel), .irqOut(irqOut)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic setPins(logic [31:0] v);
    @(negedge clk);
    pinIn = v;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(5'h14, 32'h0);
    wr(5'h18, 32'h0);
    setPins(32'h0);
    settle();
    wr(5'h10, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 32; a += 4) begin
      rd(a[4:0], d);
      check($sformatf("R1 reset read %0h", a), d, 32'h0);
    end
    check("R1 pinOe", pinOe, 32'h0);
    check("R1 pinAltSel", pinAltSel, 32'h0);
    check("R1 pinOut", pinOut, 32'h0);
    check("R1 irqOut", {31'h0, irqOut}, 32'h0);
  endtask

  task automatic t_output();
    logic [31:0] d;
    wr(5'h08, 32'hFFFF_0000);
    check("R2 pinOe", pinOe, 32'hFFFF_0000);
    wr(5'h0C, 32'hA5A5_5A5A);
    check("R2 pinOut", pinOut, 32'hA5A5_5A5A);
    rd(5'h0C, d);
    check("R3 mixed data read", d, 32'hA5A5_0000);
    rd(5'h08, d);
    check("R2 dir readback", d, 32'hFFFF_0000);
  endtask

  task automatic t_input();
    logic [31:0] d;
    @(negedge clk);
    busAddr = 5'h0C;
    pinIn = 32'h1234_5678;
    @(negedge clk); #1 d = busRdData;
    check("R3 after one edge", d, 32'hA5A5_0000);
    @(negedge clk); #1 d = busRdData;
    check("R3 after two edges", d, 32'hA5A5_5678);
    wr(5'h08, 32'h0);
    rd(5'h0C, d);
    check("R3 all inputs", d, 32'h1234_5678);
    setPins(32'h0);
    settle();
  endtask

  task automatic t_func();
    logic [31:0] d;
    wr(5'h00, 32'hC3C3_0F0F);
    rd(5'h00, d);
    check("R4 func readback", d, 32'hC3C3_0F0F);
    check("R4 pinAltSel", pinAltSel, 32'hC3C3_0F0F);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_modes();
    logic [31:0] d;
    // line0 rising (port0 pin0 -> bit 16 of 0x14), line8 falling (bit 0 of 0x14)
    // line16 both (bit 48 -> 0x18 bit 16), line24 none (0x18 bit 0)
    wr(5'h14, (32'h2 << 16) | 32'h1);
    wr(5'h18, (32'h3 << 16));
    setPins(32'h0101_0101);
    @(negedge clk); @(negedge clk);
    busAddr = 5'h10; #1 d = busRdData;
    check("R5 not set before third edge", d, 32'h0);
    @(negedge clk); #1 d = busRdData;
    check("R5 rising set on third edge", d, 32'h0001_0001);
    check("R9 irq high", {31'h0, irqOut}, 32'h1);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, d);
    check("R7 clear all", d, 32'h0);
    check("R9 irq low", {31'h0, irqOut}, 32'h0);
    setPins(32'h0);
    settle();
    rd(5'h10, d);
    check("R5 falling flags", d, 32'h0001_0100);
    quiesce();
  endtask

  task automatic t_layout();
    logic [31:0] d;
    // line13 (port1 pin5): 2*(0+5)=10 in 0x14
    wr(5'h14, 32'h2 << 10);
    setPins(32'h2000_2020);
    settle();
    rd(5'h10, d);
    check("R6 port-swapped field", d, 32'h0000_2000);
    quiesce();
    // line29 (port3 pin5): 2*(16+5)=42 -> 0x18 bit 10
    wr(5'h18, 32'h2 << 10);
    setPins(32'h2020_2020);
    settle();
    rd(5'h10, d);
    check("R6 upper word field", d, 32'h2000_0000);
    quiesce();
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h18, 32'hFFFF_FFFF);
    setPins(32'h0000_0F0F);
    settle();
    wr(5'h10, 32'h0);
    rd(5'h10, d);
    check("R7 write zero no effect", d, 32'h0000_0F0F);
    wr(5'h10, 32'h0000_0303);
    rd(5'h10, d);
    check("R7 partial clear", d, 32'h0000_0C0C);
    quiesce();
  endtask

  task automatic t_setWins();
    logic [31:0] d;
    wr(5'h14, 32'h2 << 16);
    setPins(32'h1);
    settle();
    setPins(32'h0);
    settle();
    rd(5'h10, d);
    check("R8 flag set before race", d, 32'h1);
    setPins(32'h1);
    @(negedge clk);
    wr(5'h10, 32'h1);
    rd(5'h10, d);
    check("R8 set wins over clear", d, 32'h1);
    wr(5'h10, 32'h1);
    rd(5'h10, d);
    check("R8 clear alone", d, 32'h0);
    quiesce();
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h09, 32'hFFFF_FFFF);
    rd(5'h04, d);
    check("R10 hole reads zero", d, 32'h0);
    rd(5'h09, d);
    check("R10 misaligned reads zero", d, 32'h0);
    check("R10 pinOe untouched", pinOe, 32'h0);
    check("R10 pinAltSel untouched", pinAltSel, 32'h0);
    rd(5'h14, d);
    check("R10 cfg untouched", d, 32'h0);
    rd(5'h18, d);
    check("R10 cfg hi untouched", d, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_output();
    t_input();
    t_func();
    t_modes();
    t_layout();
    t_w1c();
    t_setWins();
    t_unmapped();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule